// File: doc/BRIEF.md
# Receive Absolute Interrupt Delay Timer

This block puts an upper bound on receive interrupt latency while traffic keeps arriving. A retriggerable inactivity timer keeps moving its deadline while packets continue. This timer does not: the first packet delivered to system memory starts a countdown, and later deliveries leave that deadline unchanged. An interrupt therefore always follows within a fixed interval of the oldest pending receive.

Software programs the delay through a single 32-bit register. The low field holds the delay, counted in periods of an external fixed time-base strobe. A delay of zero turns the timer off. When the countdown ends, the block sends a one-cycle request to flush pending receive descriptor write-backs. It also raises a receive timer interrupt level, which stays high until the interrupt-clear input is pulsed.

Top module: `rx_abs_delay_timer`

## Requirements
- R1: After reset the register reads zero. Bits DLY_W-1:0 (16 by default) hold the delay and take the written data on `cfg_wr_en`. All higher read bits are always zero.
- R2: While the delay field is zero, `pkt_done` does not arm the timer, and no flush pulse and no interrupt come from the timer.
- R3: Once armed with delay D, the timer expires on the D-th `tick` sampled in a cycle after the arming cycle. The flush pulse and the interrupt appear in the cycle after that tick is sampled.
- R4: A `pkt_done` pulse while the timer is idle and the delay field is nonzero arms the timer with the current delay.
- R5: A `pkt_done` pulse while the timer is counting does not reload it and does not move the deadline.
- R6: On expiry `flush_pulse` is high for exactly that one cycle, and `rx_irq` is set in the same cycle.
- R7: `rx_irq` stays high until `irq_clr` is sampled high. When an expiry and a clear happen together, the interrupt stays set.
- R8: Writing zero to the delay field while the timer is counting cancels the countdown, with no flush and no interrupt.
- R9: A `pkt_done` in the same cycle as an expiry produces the expiry actions and then re-arms the timer from that packet.
- R10: Writing a new nonzero delay while counting does not change the running countdown. The new value applies from the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data |
| tick | input | 1 | Time-base strobe, one cycle per delay unit |
| pkt_done | input | 1 | Pulse when a received packet has reached system memory |
| irq_clr | input | 1 | Pulse to clear the interrupt |
| flush_pulse | output | 1 | One-cycle request to flush pending descriptor write-backs |
| rx_irq | output | 1 | Receive timer interrupt level |

## Verification
The bench builds the block with DLY_W = 6 and REG_W = 32. A write of all ones therefore shows 26 reserved bits reading zero. The full delay range of 1 to 63 ticks is also reachable within a short run. Random traffic uses small delays of 1 to 4, with dense ticks and packets. This makes the rare overlaps happen many times: a packet landing on the expiry cycle, a clear landing on the expiry cycle, back-to-back expiries at delay 1, and zero written mid-countdown.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic [0:0] {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;
endpackage

// File: rtl/rat_cfg_reg.sv
module rat_cfg_reg #(
    parameter int REG_W = 32,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DLY_W-1:0] wr_dly,
    output logic [DLY_W-1:0] dly,
    output logic [REG_W-1:0] rdata
);
    localparam int RSV_W = REG_W - DLY_W;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.dly = wr_dly;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dly   = s_q.dly;
    assign rdata = {{RSV_W{1'b0}}, s_q.dly};
endmodule

// File: rtl/rat_countdown.sv
module rat_countdown
    import rat_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pkt_done,
    input  logic [DLY_W-1:0] dly,
    output logic             expire
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        cd_state_e        st;
        logic [DLY_W-1:0] cnt;
    } cd_t;

    cd_t  s_d, s_q;
    logic enabled;
    logic last_tick;
    logic can_arm;

    always_comb begin
        enabled   = (dly != '0);
        last_tick = (s_q.st == CD_RUN) && tick && (s_q.cnt == ONE);
        expire    = last_tick && enabled;
        can_arm   = enabled && ((s_q.st == CD_IDLE) || expire);

        s_d = s_q;
        if (s_q.st == CD_RUN) begin
            if (!enabled) begin
                // delay field cleared by software: drop the countdown silently
                s_d.st  = CD_IDLE;
                s_d.cnt = '0;
            end else if (expire) begin
                s_d.st  = CD_IDLE;
                s_d.cnt = '0;
            end else if (tick) begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
        if (pkt_done && can_arm) begin
            s_d.st  = CD_RUN;
            s_d.cnt = dly;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= CD_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rat_event.sv
module rat_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_clr,
    output logic flush_pulse,
    output logic rx_irq
);
    typedef struct packed {
        logic flush;
        logic irq;
    } ev_t;

    ev_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.flush = expire;
        if (expire) begin
            s_d.irq = 1'b1;
        end else if (irq_clr) begin
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flush_pulse = s_q.flush;
    assign rx_irq      = s_q.irq;
endmodule

// File: rtl/rx_abs_delay_timer.sv
module rx_abs_delay_timer #(
    parameter int REG_W = 32,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             tick,
    input  logic             pkt_done,
    input  logic             irq_clr,
    output logic             flush_pulse,
    output logic             rx_irq
);
    logic [DLY_W-1:0] dly;
    logic             expire;

    rat_cfg_reg #(.REG_W(REG_W), .DLY_W(DLY_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_dly (cfg_wdata[DLY_W-1:0]),
        .dly    (dly),
        .rdata  (cfg_rdata)
    );

    rat_countdown #(.DLY_W(DLY_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pkt_done (pkt_done),
        .dly      (dly),
        .expire   (expire)
    );

    rat_event u_ev (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .irq_clr     (irq_clr),
        .flush_pulse (flush_pulse),
        .rx_irq      (rx_irq)
    );
endmodule

// File: rtl/rx_abs_delay_timer_chk.sv
module rx_abs_delay_timer_chk #(
    parameter int REG_W = 32,
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             irq_clr,
    input logic             flush_pulse,
    input logic             rx_irq
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:DLY_W] == '0);

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[DLY_W-1:0] == '0) |=> !flush_pulse);

    p_flush_sets_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> rx_irq);

    p_irq_rise_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> flush_pulse);

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !irq_clr) |=> rx_irq);
endmodule

bind rx_abs_delay_timer rx_abs_delay_timer_chk #(.REG_W(REG_W), .DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .irq_clr     (irq_clr),
    .flush_pulse (flush_pulse),
    .rx_irq      (rx_irq)
);

// File: tb/rx_abs_delay_timer_test.sv
module rx_abs_delay_timer_test;
    localparam int REG_W = 32;
    localparam int DLY_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [REG_W-1:0] cfg_wdata = '0;
    logic [REG_W-1:0] cfg_rdata;
    logic             tick = 1'b0;
    logic             pkt_done = 1'b0;
    logic             irq_clr = 1'b0;
    logic             flush_pulse;
    logic             rx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [DLY_W-1:0] m_dly = '0;
    bit               m_run = 0;
    int               m_cnt = 0;
    bit               m_irq = 0;
    bit               m_flush = 0;

    always #5 clk = ~clk;

    rx_abs_delay_timer #(.REG_W(REG_W), .DLY_W(DLY_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick(tick), .pkt_done(pkt_done), .irq_clr(irq_clr),
        .flush_pulse(flush_pulse), .rx_irq(rx_irq)
    );

    function automatic logic [REG_W-1:0] exp_rdata();
        return {{(REG_W-DLY_W){1'b0}}, m_dly};
    endfunction

    // advance the reference by one sampled edge, from the requirement text
    function automatic void model_step(bit wr, logic [REG_W-1:0] wd, bit tk, bit pk, bit cl);
        bit ex;
        ex = m_run && tk && (m_cnt == 1) && (m_dly != 0);
        if (m_run && m_dly == 0) m_run = 0;           // R8 cancel
        else if (ex) m_run = 0;                       // R3 expiry
        else if (m_run && tk) m_cnt = m_cnt - 1;
        if (pk && m_dly != 0 && (!m_run || ex)) begin // R4, R5, R9
            m_run = 1;
            m_cnt = int'(m_dly);
        end
        m_flush = ex;                                 // R6
        if (ex) m_irq = 1;                            // R7
        else if (cl) m_irq = 0;
        if (wr) m_dly = wd[DLY_W-1:0];                // R1
    endfunction

    task automatic check(string req, string what, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(string req, bit wr, logic [REG_W-1:0] wd, bit tk, bit pk, bit cl);
        @(negedge clk);
        cfg_wr_en = wr; cfg_wdata = wd; tick = tk; pkt_done = pk; irq_clr = cl;
        @(posedge clk);
        model_step(wr, wd, tk, pk, cl);
        #2;
        check(req, "flush_pulse", REG_W'(flush_pulse), REG_W'(m_flush));
        check(req, "rx_irq", REG_W'(rx_irq), REG_W'(m_irq));
        check(req, "cfg_rdata", cfg_rdata, exp_rdata());
    endtask

    task automatic idle(string req, int n, bit tk);
        for (int i = 0; i < n; i++) cyc(req, 0, '0, tk, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1", "reset rdata", cfg_rdata, '0);
        check("R1", "reset irq", REG_W'(rx_irq), '0);
        check("R6", "reset flush", REG_W'(flush_pulse), '0);

        // R1: reserved bits read zero
        cyc("R1", 1, '1, 0, 0, 0);
        check("R1", "all-ones readback", cfg_rdata, REG_W'(63));

        // R2: zero delay, packets and ticks give nothing
        cyc("R2", 1, '0, 0, 0, 0);
        for (int i = 0; i < 10; i++) cyc("R2", 0, '0, 1, 1, 0);
        check("R2", "no irq", REG_W'(rx_irq), '0);

        // R3/R4: delay 3, tick in arming cycle not counted
        cyc("R4", 1, 32'd3, 0, 0, 0);
        cyc("R4", 0, '0, 1, 1, 0);
        cyc("R3", 0, '0, 1, 0, 0);
        cyc("R3", 0, '0, 1, 0, 0);
        check("R3", "no flush before 3rd tick", REG_W'(flush_pulse), '0);
        cyc("R3", 0, '0, 1, 0, 0);
        check("R3", "flush after 3rd tick", REG_W'(flush_pulse), REG_W'(1));
        cyc("R6", 0, '0, 0, 0, 0);
        check("R6", "flush one cycle", REG_W'(flush_pulse), '0);
        check("R7", "irq held", REG_W'(rx_irq), REG_W'(1));
        cyc("R7", 0, '0, 0, 0, 1);
        check("R7", "irq cleared", REG_W'(rx_irq), '0);

        // R5: further packets do not push the deadline
        cyc("R5", 0, '0, 0, 1, 0);
        cyc("R5", 0, '0, 1, 1, 0);
        cyc("R5", 0, '0, 1, 1, 0);
        cyc("R5", 0, '0, 1, 0, 0);
        check("R5", "deadline kept", REG_W'(flush_pulse), REG_W'(1));

        // R7: clear coinciding with expiry keeps irq
        cyc("R7", 0, '0, 0, 1, 0);
        idle("R7", 2, 1);
        cyc("R7", 0, '0, 1, 0, 1);
        check("R7", "expiry beats clear", REG_W'(rx_irq), REG_W'(1));
        cyc("R7", 0, '0, 0, 0, 1);

        // R8: zero written mid-count cancels
        cyc("R8", 0, '0, 0, 1, 0);
        cyc("R8", 0, '0, 1, 0, 0);
        cyc("R8", 1, '0, 0, 0, 0);
        cyc("R8", 1, 32'd3, 1, 0, 0);
        idle("R8", 6, 1);
        check("R8", "cancelled irq", REG_W'(rx_irq), '0);

        // R9: packet on expiry cycle re-arms
        cyc("R9", 0, '0, 0, 1, 0);
        idle("R9", 2, 1);
        cyc("R9", 0, '0, 1, 1, 0);
        cyc("R9", 0, '0, 0, 0, 1);
        idle("R9", 2, 1);
        cyc("R9", 0, '0, 1, 0, 0);
        check("R9", "rearmed expiry", REG_W'(flush_pulse), REG_W'(1));

        // R10: new value while running applies next time
        cyc("R10", 0, '0, 0, 0, 1);
        cyc("R10", 0, '0, 0, 1, 0);
        cyc("R10", 1, 32'd63, 1, 0, 0);
        idle("R10", 2, 1);
        check("R10", "old count used", REG_W'(flush_pulse), REG_W'(1));
        cyc("R10", 0, '0, 0, 1, 1);
        idle("R10", 63, 1);
        check("R10", "full-range expiry", REG_W'(flush_pulse), REG_W'(1));

        // constrained random traffic covering R2-R10 against the reference
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            bit wr = ($urandom % 40) == 0;
            logic [REG_W-1:0] wd = {$urandom} & 32'hFFFF_FFC0 | REG_W'($urandom % 5);
            cyc("RAND", wr, wd, ($urandom % 2) == 0, ($urandom % 6) == 0, ($urandom % 12) == 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule